// File: doc/BRIEF.md
# Framing Byte Inserter with Error Injection

This block places the two framing byte groups at the head of every STS-12 transmit frame on one channel. A one-cycle transmit frame pulse marks the first byte slot of a frame. The byte presented on the input in that cycle is slot 0, and each later cycle carries the next slot. The block overwrites slots 0 to 11 with the first framing value and slots 12 to 23 with the second. Every other slot passes through untouched. The output trails the input by a fixed pipeline of six cycles, so the first framing byte appears six cycles after the pulse.

For link testing, two user-defined corrupt values can replace the defaults. Only the boundary pair is affected: the last byte of the first group and the first byte of the second. A per-channel enable starts a burst. The burst lasts a programmed number of frames, or lasts indefinitely when that number is zero. Once a finite burst has run out, the block stays quiet until the enable is dropped and raised again. The enable and the frame count are sampled only at frame pulses, so no frame is ever partly corrupted. A separate control turns insertion off entirely, and then every slot passes through unchanged.

Top module: `frame_byte_inserter`

## Requirements
- R1: While reset is asserted, `dout` reads 0x00 regardless of `din`.
- R2: With corruption inactive, output slots 0..11 of a frame read 0xF6 and slots 12..23 read 0x28. Slot k of a frame whose pulse is driven in cycle c appears on `dout` in cycle c+6+k.
- R3: Slots 24 and beyond reproduce the input byte of the same slot, six cycles later.
- R4: When `err_en` is high at a pulse and `err_frames` = N > 0, slot 11 carries `err_a1` and slot 12 carries `err_a2` for exactly N consecutive frames, starting with that frame. The other 22 framing slots keep their defaults.
- R5: When `err_frames` is 0 at the pulse that starts a burst, corruption repeats in every frame until a pulse finds `err_en` low. That frame and later ones carry the defaults.
- R6: After a finite burst has run out, a held-high `err_en` starts no new burst. A pulse that finds `err_en` low re-arms the block, and a later pulse with `err_en` high starts a fresh burst.
- R7: A change of `err_en` between pulses does not affect the frame in progress. The new value takes effect at the next pulse.
- R8: While `insert_off` is high, every slot, framing slots included, reproduces the input byte six cycles later, and no corrupt value appears.
- R9: The burst length is latched when the burst starts. Changing `err_frames` during a burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_sof | input | 1 | Transmit frame pulse; the current input byte is slot 0 |
| din | input | 8 | Outgoing byte stream, one slot per cycle |
| err_en | input | 1 | Per-channel corruption enable, sampled at pulses |
| err_a1 | input | 8 | Corrupt value for slot 11 |
| err_a2 | input | 8 | Corrupt value for slot 12 |
| err_frames | input | CNT_W | Burst length in frames; 0 means unlimited |
| insert_off | input | 1 | High: framing slots pass through unchanged |
| dout | output | 8 | Byte stream with framing applied, six cycles behind |

## Verification
Two behaviours can land on the same frame pulse: the end of a finite burst, and the sampling of an enable that is still high. The bench arranges this by holding `err_en` high across the pulse where the frame budget runs out. It then expects that frame and the following one to carry default values at slots 11 and 12. A second collision is provoked by moving `err_en` in the middle of a frame, just before the corrupt slots arrive. The bench expects the frame in progress to keep the state chosen at its own pulse, and the change to show only from the next frame on.

// File: rtl/fbi_pkg.sv
`timescale 1ns/1ps
package fbi_pkg;
    typedef logic [7:0] byte_t;
    localparam byte_t A1_DEFAULT = 8'hF6;
    localparam byte_t A2_DEFAULT = 8'h28;
endpackage

// File: rtl/fbi_slot_counter.sv
`timescale 1ns/1ps
module fbi_slot_counter #(
    parameter int GRP_BYTES = 12,
    localparam int TOTAL = 2 * GRP_BYTES,
    localparam int IDX_W = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    output logic [IDX_W-1:0] slot,
    output logic             in_frame
);
    typedef struct packed {
        logic [IDX_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [IDX_W-1:0] cur;

    always_comb begin
        st_d     = st_q;
        cur      = sof ? '0 : st_q.cnt;
        in_frame = (cur < IDX_W'(TOTAL));
        slot     = cur;
        if (in_frame) begin
            st_d.cnt = cur + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= IDX_W'(TOTAL);
        end else begin
            st_q <= st_d;
        end
    end

    // Slot index after a pulse must advance to 1 when no new pulse arrives.
    assert_slot_follows_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && $past(sof)) |-> (slot == IDX_W'(1) && in_frame));
endmodule

// File: rtl/fbi_burst_ctrl.sv
`timescale 1ns/1ps
module fbi_burst_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             err_en,
    input  logic [CNT_W-1:0] frames,
    output logic             corrupt_on
);
    typedef struct packed {
        logic             active;
        logic             endless;
        logic             done;
        logic [CNT_W-1:0] left;
    } burst_st_t;

    burst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sof) begin
            if (!err_en) begin
                st_d.active  = 1'b0;
                st_d.endless = 1'b0;
                st_d.done    = 1'b0;
                st_d.left    = '0;
            end else if (st_q.active) begin
                if (!st_q.endless) begin
                    if (st_q.left == CNT_W'(1)) begin
                        st_d.active = 1'b0;
                        st_d.done   = 1'b1;
                        st_d.left   = '0;
                    end else begin
                        st_d.left = st_q.left - 1'b1;
                    end
                end
            end else if (!st_q.done) begin
                st_d.active  = 1'b1;
                st_d.endless = (frames == '0);
                st_d.left    = frames;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign corrupt_on = st_q.active;

    // A finite burst never runs with an empty budget.
    assert_budget_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.endless) |-> (st_q.left != '0));

    // A burst only starts on a pulse that saw the enable high.
    assert_start_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corrupt_on) |-> ($past(sof) && $past(err_en)));

    // Active and finished are never both set.
    assert_active_done_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.active && st_q.done));

    // Re-arm happens only on a pulse that saw the enable low.
    assert_rearm_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.done) |-> ($past(sof) && !$past(err_en)));

    // Corruption state never moves between pulses.
    assert_hold_between_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sof) |-> $stable(corrupt_on));
endmodule

// File: rtl/fbi_delay_line.sv
`timescale 1ns/1ps
module fbi_delay_line #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe_d [DEPTH];
    logic [WIDTH-1:0] pipe_q [DEPTH];

    assign pipe_d[0] = d;

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        assign pipe_d[g] = pipe_q[g-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign q = pipe_q[DEPTH-1];

    // The output is cleared while reset is held.
    assert_cleared_in_reset_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (q == '0));
endmodule

// File: rtl/frame_byte_inserter.sv
`timescale 1ns/1ps
module frame_byte_inserter
    import fbi_pkg::*;
#(
    parameter int GRP_BYTES = 12,
    parameter int LATENCY   = 6,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = $clog2(2 * GRP_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_sof,
    input  logic [7:0]       din,
    input  logic             err_en,
    input  logic [7:0]       err_a1,
    input  logic [7:0]       err_a2,
    input  logic [CNT_W-1:0] err_frames,
    input  logic             insert_off,
    output logic [7:0]       dout
);
    logic [IDX_W-1:0] slot;
    logic             in_frame;
    logic             corrupt_on;
    byte_t            sel_byte;

    fbi_slot_counter #(.GRP_BYTES(GRP_BYTES)) slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (tx_sof),
        .slot     (slot),
        .in_frame (in_frame)
    );

    fbi_burst_ctrl #(.CNT_W(CNT_W)) burst_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (tx_sof),
        .err_en     (err_en),
        .frames     (err_frames),
        .corrupt_on (corrupt_on)
    );

    always_comb begin
        sel_byte = din;
        if (!insert_off && in_frame) begin
            if (slot < IDX_W'(GRP_BYTES)) begin
                sel_byte = (corrupt_on && slot == IDX_W'(GRP_BYTES - 1)) ? err_a1 : A1_DEFAULT;
            end else begin
                sel_byte = (corrupt_on && slot == IDX_W'(GRP_BYTES)) ? err_a2 : A2_DEFAULT;
            end
        end
    end

    fbi_delay_line #(.WIDTH(8), .DEPTH(LATENCY)) delay_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sel_byte),
        .q     (dout)
    );

    // Bypass must never put a corrupt value in place of the input byte.
    assert_bypass_passes_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        insert_off |-> (sel_byte == din));
endmodule

// File: tb/frame_byte_inserter_tb_top.sv
`timescale 1ns/1ps
module frame_byte_inserter_tb_top;
    localparam int FL  = 40;
    localparam int LAT = 6;
    localparam int GRP = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_sof = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        err_en = 1'b0;
    logic [7:0]  err_a1 = 8'h5A;
    logic [7:0]  err_a2 = 8'hC3;
    logic [15:0] err_frames = 16'd0;
    logic        insert_off = 1'b0;
    logic [7:0]  dout;

    int total = 0;
    int bad = 0;
    int seed = 1;

    always #5 clk = ~clk;

    frame_byte_inserter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_sof     (tx_sof),
        .din        (din),
        .err_en     (err_en),
        .err_a1     (err_a1),
        .err_a2     (err_a2),
        .err_frames (err_frames),
        .insert_off (insert_off),
        .dout       (dout)
    );

    function automatic logic [7:0] pat(int s, int k);
        return 8'((s * 31) + (k * 13) + 5);
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag, int k);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s slot %0d: actual=%02h expected=%02h", tag, k, act, exp);
        end
    endtask

    // One frame: pulse in cycle 0; slots 0..FL-LAT-1 of this frame are checked.
    task automatic run_frame(bit cor, string tag, int tog_at, bit tog_val);
        logic [7:0] exp;
        string t;
        for (int j = 0; j < FL; j++) begin
            @(negedge clk);
            if (j >= LAT) begin
                int k = j - LAT;
                t = (k < 2 * GRP) ? "R2" : "R3";
                if (insert_off) begin
                    exp = pat(seed, k);
                    t = "R8";
                end else if (k < GRP) begin
                    exp = (cor && k == GRP - 1) ? err_a1 : 8'hF6;
                end else if (k < 2 * GRP) begin
                    exp = (cor && k == GRP) ? err_a2 : 8'h28;
                end else begin
                    exp = pat(seed, k);
                end
                if (k == GRP - 1 || k == GRP) t = tag;
                check(dout, exp, t, k);
            end
            tx_sof = (j == 0);
            din = pat(seed, j);
            if (j == tog_at) err_en = tog_val;
        end
        seed++;
    endtask

    task automatic t_reset();
        din = 8'h77;
        repeat (3) @(negedge clk);
        check(dout, 8'h00, "R1", 0);
        @(negedge clk);
        check(dout, 8'h00, "R1", 0);
        rst_n = 1'b1;
    endtask

    task automatic t_default();
        run_frame(1'b0, "R2", -1, 1'b0);
        run_frame(1'b0, "R2", -1, 1'b0);
    endtask

    task automatic t_burst();
        err_frames = 16'd3;
        err_en = 1'b1;
        run_frame(1'b1, "R4", -1, 1'b0);
        err_frames = 16'd7;          // R9: must not stretch the running burst
        run_frame(1'b1, "R4", -1, 1'b0);
        run_frame(1'b1, "R9", -1, 1'b0);
        run_frame(1'b0, "R9", -1, 1'b0);
        run_frame(1'b0, "R6", -1, 1'b0);  // enable held high: no retrigger
    endtask

    task automatic t_rearm();
        err_en = 1'b0;
        run_frame(1'b0, "R6", -1, 1'b0);
        err_frames = 16'd1;
        err_en = 1'b1;
        run_frame(1'b1, "R6", -1, 1'b0);
        run_frame(1'b0, "R6", -1, 1'b0);
    endtask

    task automatic t_forever();
        err_en = 1'b0;
        run_frame(1'b0, "R5", -1, 1'b0);
        err_frames = 16'd0;
        err_en = 1'b1;
        for (int f = 0; f < 4; f++) run_frame(1'b1, "R5", -1, 1'b0);
        err_en = 1'b0;
        run_frame(1'b0, "R5", -1, 1'b0);
    endtask

    task automatic t_midframe();
        err_en = 1'b0;
        err_frames = 16'd0;
        run_frame(1'b0, "R7", 5, 1'b1);
        run_frame(1'b1, "R7", -1, 1'b0);
        run_frame(1'b1, "R7", 5, 1'b0);
        run_frame(1'b0, "R7", -1, 1'b0);
    endtask

    task automatic t_bypass();
        err_frames = 16'd0;
        err_en = 1'b1;
        insert_off = 1'b1;
        run_frame(1'b1, "R8", -1, 1'b0);
        run_frame(1'b1, "R8", -1, 1'b0);
        insert_off = 1'b0;
        run_frame(1'b1, "R5", -1, 1'b0);
        err_en = 1'b0;
        run_frame(1'b0, "R2", -1, 1'b0);
    endtask

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        t_default();
        t_burst();
        t_rearm();
        t_forever();
        t_midframe();
        t_bypass();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(100000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule